// File: doc/BRIEF.md
# PCI Express Capability Register Block

This block holds a three-dword PCI Express capability structure for a device's configuration space. A register port addresses it by dword index (0, 1 or 2) and carries a read strobe, a write strobe and 32-bit write data. The three dwords are an identification header, a device capability word and a combined control/status word. Any other index reads as zero, and writes to it do nothing.

The control half stores the function's device control settings. Its top bit is an initiate-reset command: it is never stored, and when the function advertises reset support it fires a one-cycle request toward the function's reset logic. A strap input decides whether that support is advertised. The status half holds four error flags. Event inputs set them, and software clears them by writing ones. A synchronous active-low reset returns all stored state to zero.

Top module: `pcie_cap_regs`

## Requirements
- R1: While reset is low and after it is released, `flr_req` is 0, `reg_rdata` is 0, and a read of index 2 returns 0x00000000.
- R2: A read of index 0 returns 0x00020010: ID 0x10 in bits 7:0, next pointer 0x00 in bits 15:8, 0x0002 in bits 31:16.
- R3: A read of index 1 returns bit 28 equal to `flr_strap` and all other bits 0.
- R4: Writes to index 0 or 1 change nothing, and later reads of those indices return the same values.
- R5: A write to index 2 stores bits 14:0 as device control (read back in bits 14:0), and bit 15 always reads back 0.
- R6: Every write to index 2 with data bit 15 set while `flr_strap` is 1 makes `flr_req` high for exactly the cycle after the write. This includes a write of 0x8000 directly after 0x8001. With `flr_strap` at 0, `flr_req` stays low.
- R7: A high `err_evt[i]` (i = 0..3) sets status flag i, which reads in bit 16+i of index 2.
- R8: A write to index 2 clears flag i only where data bit 16+i is 1. A 0 in that bit leaves the flag unchanged.
- R9: When `err_evt[i]` and a clearing write hit flag i in the same cycle, the flag ends up set.
- R10: A read of any index above 2 returns 0, and a write there changes no register.
- R11: `reg_rdata` updates on the clock edge that samples `reg_rd` and holds its value until the next read. Bits 31:20 of index 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flr_strap | input | 1 | Advertise and enable function-level reset |
| reg_idx | input | IDX_W (4) | Dword index into the structure |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| err_evt | input | 4 | Error-event pulses: correctable, non-fatal, fatal, unsupported request |
| flr_req | output | 1 | One-cycle function-level-reset request |

## Verification
Two functions can act on the same status flag in the same clock: an error event setting it and a software write clearing it. The bench drives an event on one flag during a write that writes ones to that flag and to two others. It then reads index 2 and expects the event's flag still set and the other two cleared. It also issues back-to-back reset-command writes. Each must produce its own request pulse, even though the stored command bit never reads as 1.

// File: rtl/pcie_cap_pkg.sv
// Package: shared constants and the register-select type for the
// capability register block. Assumes a 32-bit register port.
package pcie_cap_pkg;
    localparam int DW          = 32;
    localparam int N_ERR       = 4;
    localparam int CTL_W       = 16;
    localparam int FLR_CAP_BIT = 28;
    localparam int FLR_CTL_BIT = 15;
    localparam int ERR_LSB     = 16;

    localparam logic [7:0]  CAP_ID   = 8'h10;
    localparam logic [7:0]  NEXT_PTR = 8'h00;
    localparam logic [15:0] CAP_VER  = 16'h0002;

    typedef enum logic [1:0] {
        SEL_HDR    = 2'd0,
        SEL_DEVCAP = 2'd1,
        SEL_CTLSTS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cap_addr_dec.sv
// Module: turns a dword index into a register select.
// Assumes: indices 0..2 are mapped, and every other index selects nothing.
module cap_addr_dec
    import pcie_cap_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    output reg_sel_e         sel
);
    // Decode the index into one of the three dwords or none.
    always_comb begin
        if (idx == IDX_W'(0))      sel = SEL_HDR;
        else if (idx == IDX_W'(1)) sel = SEL_DEVCAP;
        else if (idx == IDX_W'(2)) sel = SEL_CTLSTS;
        else                       sel = SEL_NONE;
    end
endmodule

// File: rtl/cap_ctl_reg.sv
// Module: device control storage and the reset-command pulse.
// Assumes: wr_ctl is a one-cycle write of the control/status dword. The
// command bit is never stored, so every write with it set fires a request.
module cap_ctl_reg
    import pcie_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic [CTL_W-1:0] wdata,
    input  logic             flr_en,
    output logic [CTL_W-1:0] ctl,
    output logic             flr_req
);
    // Store the control bits, keeping the command bit at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl <= '0;
        else if (wr_ctl) ctl <= {1'b0, wdata[FLR_CTL_BIT-1:0]};
    end

    // Register a one-cycle request for each enabled command write.
    always_ff @(posedge clk) begin
        if (!rst_n) flr_req <= 1'b0;
        else        flr_req <= wr_ctl && wdata[FLR_CTL_BIT] && flr_en;
    end
endmodule

// File: rtl/cap_err_sts.sv
// Module: error flags that events set and software clears by writing ones.
// Assumes: an event and a clear on the same flag in one cycle leave it set.
module cap_err_sts #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctl,
    input  logic [N-1:0] w1c,
    input  logic [N-1:0] evt,
    output logic [N-1:0] sts
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Update one flag: an event sets it, a written one clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)                sts[i] <= 1'b0;
            else if (evt[i])           sts[i] <= 1'b1;
            else if (wr_ctl && w1c[i]) sts[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/cap_rd_mux.sv
// Module: builds the selected dword and registers it as read data.
// Assumes: the data is taken only on a read strobe and held otherwise.
module cap_rd_mux
    import pcie_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  reg_sel_e         sel,
    input  logic             flr_en,
    input  logic [CTL_W-1:0] ctl,
    input  logic [N_ERR-1:0] sts,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] rd_next;

    // Form the read value of the selected dword.
    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_HDR:    rd_next = {CAP_VER, NEXT_PTR, CAP_ID};
            SEL_DEVCAP: rd_next[FLR_CAP_BIT] = flr_en;
            SEL_CTLSTS: rd_next = {{(DW-CTL_W-N_ERR){1'b0}}, sts, ctl};
            default:    rd_next = '0;
        endcase
    end

    // Capture the read value on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_next;
    end
endmodule

// File: rtl/pcie_cap_regs.sv
// Module: top of the capability register block. It decodes the index and
// routes writes to the control and status stores and reads through the mux.
// Assumes: single-cycle strobes, synchronous active-low reset, and a static
// strap. A read in the same cycle as a write returns the pre-write value.
module pcie_cap_regs
    import pcie_cap_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flr_strap,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [N_ERR-1:0] err_evt,
    output logic             flr_req
);
    reg_sel_e         sel;
    logic             wr_ctl;
    logic [CTL_W-1:0] ctl;
    logic [N_ERR-1:0] sts;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[DW-1:ERR_LSB+N_ERR];

    cap_addr_dec #(.IDX_W(IDX_W)) dec_i (.idx(reg_idx), .sel(sel));

    // Only the control/status dword accepts writes.
    assign wr_ctl = reg_wr && (sel == SEL_CTLSTS);

    cap_ctl_reg ctl_i (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl),
        .wdata(reg_wdata[CTL_W-1:0]), .flr_en(flr_strap),
        .ctl(ctl), .flr_req(flr_req)
    );

    cap_err_sts #(.N(N_ERR)) sts_i (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl),
        .w1c(reg_wdata[ERR_LSB +: N_ERR]), .evt(err_evt), .sts(sts)
    );

    cap_rd_mux rd_i (
        .clk(clk), .rst_n(rst_n), .rd(reg_rd), .sel(sel),
        .flr_en(flr_strap), .ctl(ctl), .sts(sts), .rdata(reg_rdata)
    );
endmodule

// File: rtl/pcie_cap_regs_chk.sv
// Checker: port-level properties of the capability register block.
module pcie_cap_regs_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flr_strap,
    input logic [IDX_W-1:0] reg_idx,
    input logic             reg_rd,
    input logic             reg_wr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic [3:0]       err_evt,
    input logic             flr_req
);
    p_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_idx == IDX_W'(0)) |-> reg_rdata == 32'h0002_0010);

    p_devcap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_idx == IDX_W'(1)) |-> reg_rdata == {3'b000, $past(flr_strap), 28'h0});

    p_flr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flr_req |-> $past(reg_wr && reg_idx == IDX_W'(2) && reg_wdata[15] && flr_strap));

    p_flr_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && reg_idx == IDX_W'(2) && reg_wdata[15] && flr_strap) |-> flr_req);

    p_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_idx > IDX_W'(2)) |-> reg_rdata == 32'h0);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !reg_rd) |-> $stable(reg_rdata));

    p_zero_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_idx == IDX_W'(2)) |-> (reg_rdata[31:20] == 12'h0 && !reg_rdata[15]));
endmodule

bind pcie_cap_regs pcie_cap_regs_chk #(.IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .flr_strap(flr_strap), .reg_idx(reg_idx),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_evt(err_evt), .flr_req(flr_req)
);

// File: tb/pcie_cap_regs_tb_top.sv
// Bench: a scoreboard for the capability register block. Read tasks queue
// expected data, and a monitor compares it one clock later.
module pcie_cap_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flr_strap = 1'b1;
    logic [3:0]  reg_idx = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  err_evt = '0;
    logic        flr_req;

    int checks = 0;
    int errors = 0;
    int flr_cnt = 0;
    logic        pend = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pcie_cap_regs #(.IDX_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .flr_strap(flr_strap), .reg_idx(reg_idx),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_evt(err_evt), .flr_req(flr_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Monitor: note reads at the edge, then compare the result at the falling edge.
    always @(posedge clk) pend <= reg_rd;
    always @(negedge clk) begin
        if (flr_req) flr_cnt++;
        if (pend && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(reg_rdata === e, t, reg_rdata, e);
        end
    end

    task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_idx = idx; reg_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d, input logic [3:0] evt);
        @(negedge clk);
        reg_idx = idx; reg_wdata = d; reg_wr = 1'b1; err_evt = evt;
        @(negedge clk);
        reg_wr = 1'b0; err_evt = '0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%08h expected=%08h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        chk(flr_req === 1'b0, "R1 flr_req in reset", {31'h0, flr_req}, 32'h0);
        chk(reg_rdata === 32'h0, "R1 rdata in reset", reg_rdata, 32'h0);
        rst_n = 1'b1;
        rd(4'd2, 32'h0000_0000, "R1 ctl/sts after reset");
        rd(4'd0, 32'h0002_0010, "R2 header");
        rd(4'd1, 32'h1000_0000, "R3 devcap strap=1");
        wr(4'd0, 32'hFFFF_FFFF, 4'h0);
        wr(4'd1, 32'hFFFF_FFFF, 4'h0);
        rd(4'd0, 32'h0002_0010, "R4 header after write");
        rd(4'd1, 32'h1000_0000, "R4 devcap after write");
        wr(4'd2, 32'h0000_0001, 4'h0);
        rd(4'd2, 32'h0000_0001, "R5 ctl store");
        chk(flr_cnt == 0, "R6 no pulse without bit15", flr_cnt, 0);
        wr(4'd2, 32'h0000_8001, 4'h0);
        rd(4'd2, 32'h0000_0001, "R5 bit15 reads 0");
        chk(flr_cnt == 1, "R6 pulse on 0x8001", flr_cnt, 1);
        wr(4'd2, 32'h0000_8000, 4'h0);
        rd(4'd2, 32'h0000_0000, "R5 ctl after 0x8000");
        chk(flr_cnt == 2, "R6 repeat pulse on 0x8000", flr_cnt, 2);
        chk(flr_req === 1'b0, "R6 pulse is one cycle", {31'h0, flr_req}, 32'h0);
        // Back-to-back command writes give two pulses.
        @(negedge clk);
        reg_idx = 4'd2; reg_wdata = 32'h0000_8000; reg_wr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
        chk(flr_cnt == 4, "R6 back-to-back pulses", flr_cnt, 4);
        flr_strap = 1'b0;
        base = flr_cnt;
        wr(4'd2, 32'h0000_8000, 4'h0);
        chk(flr_cnt == base, "R6 no pulse with strap=0", flr_cnt, base);
        rd(4'd1, 32'h0000_0000, "R3 devcap strap=0");
        wr(4'd2, 32'h0000_7FFF, 4'h0);
        rd(4'd2, 32'h0000_7FFF, "R5 ctl bits 14:0");
        wr(4'd3, 32'h0, 4'hF);
        rd(4'd2, 32'h000F_7FFF, "R7 events set flags");
        wr(4'd2, 32'h0001_7FFF, 4'h0);
        rd(4'd2, 32'h000E_7FFF, "R8 write one clears flag 0");
        wr(4'd2, 32'h0000_7FFF, 4'h0);
        rd(4'd2, 32'h000E_7FFF, "R8 write zero keeps flags");
        wr(4'd2, 32'h000E_7FFF, 4'b0010);
        rd(4'd2, 32'h0002_7FFF, "R9 event beats clear");
        wr(4'd4, 32'hFFFF_FFFF, 4'h0);
        rd(4'd2, 32'h0002_7FFF, "R10 write to index 4 no effect");
        rd(4'd4, 32'h0000_0000, "R10 index 4 reads 0");
        rd(4'd15, 32'h0000_0000, "R10 index 15 reads 0");
        wr(4'd2, 32'hFFFF_FFFF, 4'h0);
        rd(4'd2, 32'h0000_7FFF, "R11 bits 31:20 zero");
        repeat (3) @(negedge clk);
        chk(reg_rdata === 32'h0000_7FFF, "R11 rdata holds", reg_rdata, 32'h0000_7FFF);
        wr(4'd3, 32'h0, 4'hF);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(4'd2, 32'h0000_0000, "R1 state cleared by reset");
        finish_run();
    end
endmodule